// File: doc/BRIEF.md
# Operating Mode Controller for a Small Microcontroller

This block decides which of four operating modes a small 8-bit microcontroller is in: full-speed run, slow run, a halted wait state ("green") and full power down. Software changes the mode by writing a four-bit control word. From these bits the block drives the enables of the high-speed and low-speed oscillators, the system clock source select and a CPU run enable. It also drives a clock-enable strobe that runs every cycle at full speed and once per divider period in slow mode.

Wake-up comes from level changes on two input ports. Every port-0 pin can wake the part. A port-1 pin can wake it only when its bit in a per-pin enable mask is set. The halted wait state can also end on a timer wake input. Where the part resumes depends on which halted state it left. A power-down wake always resumes at full speed with the control word cleared. A wait-state wake resumes the run mode that the wait state was entered with. The clock select follows the requested mode only at a divider cycle boundary, so the selected clock never shows a truncated pulse.

Top module: `opm_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0 (full speed), `ctl_o` is 0, both oscillator enables are 1, `cpu_run` is 1 and `clk_sel_slow` is 0.
- R2: Control word layout is bit0 slow select, bit1 stop high oscillator, bit2 power down and bit3 wait. `mode_o` encodes 0 full speed, 1 slow, 2 wait and 3 power down. A write with bit2=0, bit3=0 and bit0=1 enters slow mode (1). A write with all four bits at 0 selects full speed (0). A written word is returned on `ctl_o` one cycle later.
- R3: In slow mode, `hosc_en` equals the inverse of bit1 and `losc_en` and `cpu_run` are 1. In full-speed mode, `hosc_en` is 1.
- R4: A write with bit2=1 enters power down (3) whatever the other bits are. In power down, `hosc_en`, `losc_en`, `cpu_run` and `sys_ce` are all 0.
- R5: A write with bit2=0, bit1=1 and bit0=0 leaves no clock source, so it enters power down (3) even when bit3 is set.
- R6: While halted (mode 2 or 3), a level change on any port-0 pin, or on a port-1 pin whose `p1_wake_en` bit is 1, ends the halt within four clock cycles. A change on a port-1 pin whose enable bit is 0 leaves the block halted.
- R7: A wake from power down always goes to full speed (0) and clears `ctl_o` to 0, which includes the power-down bit.
- R8: A write with bit3=1 that R4 and R5 do not turn into power down enters wait (2). In wait, `cpu_run` is 0, `losc_en` is 1 and `hosc_en` is the inverse of bit1. A wake from wait resumes mode 1 if bit0 was 1 and mode 0 otherwise, and clears only bit3 of `ctl_o`. `green_wake` also ends wait, but it has no effect in power down.
- R9: While `cpu_run` is 0, control writes are ignored: both `mode_o` and `ctl_o` hold.
- R10: `clk_sel_slow` changes only at the end of a DIV-cycle divider period, so it follows a mode change within DIV cycles. At full speed `sys_ce` is 1 every cycle. In slow mode it pulses once every DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word: slow, stop-high, power-down, wait |
| p0_pins | input | P0_W | Port 0 pin levels, all wake sources |
| p1_pins | input | P1_W | Port 1 pin levels |
| p1_wake_en | input | P1_W | Per-pin wake enable for port 1 |
| green_wake | input | 1 | Timer wake request for the wait state |
| mode_o | output | 2 | Current mode code |
| ctl_o | output | 4 | Current control word |
| hosc_en | output | 1 | High-speed oscillator enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| cpu_run | output | 1 | CPU instruction execution enable |
| clk_sel_slow | output | 1 | Applied clock source select, 1 = divided low-speed |
| sys_ce | output | 1 | System clock-enable strobe |

## Verification
The bench sweeps all sixteen control words from both run modes. It checks the priority of power down over the no-clock case and of both over the wait state. A design that gave the wait bit priority would halt with the high oscillator stopped and then resume into a mode with no clock. Each port pin is toggled in turn with its wake enable on and off: a mask applied backwards would wake on a disabled pin or never wake on an enabled one. The return mode after each halt is checked against the bits that were written. A design that returns to slow after power down, or that leaves the power-down bit set, shows up in `mode_o` and `ctl_o`. The timing of the clock select is measured against the divider period.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [1:0] {
    OPM_NORMAL = 2'd0,
    OPM_SLOW   = 2'd1,
    OPM_GREEN  = 2'd2,
    OPM_DOWN   = 2'd3
  } opm_mode_e;

  localparam int CTL_W      = 4;
  localparam int CTL_SLOW   = 0;
  localparam int CTL_STOPHI = 1;
  localparam int CTL_PDOWN  = 2;
  localparam int CTL_GREEN  = 3;

  // Run mode that the word selects, ignoring the wait bit.
  function automatic opm_mode_e base_mode(input logic [CTL_W-1:0] d);
    if (d[CTL_PDOWN])
      return OPM_DOWN;
    else if (!d[CTL_SLOW] && d[CTL_STOPHI])
      return OPM_DOWN;
    else if (d[CTL_SLOW])
      return OPM_SLOW;
    else
      return OPM_NORMAL;
  endfunction

  // Mode entered after a write, taking the wait bit into account.
  function automatic opm_mode_e target_mode(input logic [CTL_W-1:0] d);
    opm_mode_e b;
    b = base_mode(d);
    if (b != OPM_DOWN && d[CTL_GREEN])
      return OPM_GREEN;
    else
      return b;
  endfunction

  function automatic logic is_running(input opm_mode_e m);
    return (m == OPM_NORMAL) || (m == OPM_SLOW);
  endfunction

  function automatic logic hosc_needed(input opm_mode_e m, input logic stop_hi);
    case (m)
      OPM_NORMAL: return 1'b1;
      OPM_DOWN:   return 1'b0;
      default:    return !stop_hi;
    endcase
  endfunction

endpackage

// File: rtl/opm_sync.sv
module opm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/opm_wake_det.sv
module opm_wake_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] mask_i,
  input  logic         capture_i,
  input  logic         armed_i,
  output logic         change_o
);

  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (capture_i) snap_q <= pins_i;
  end

  assign change_o = armed_i && (|((pins_i ^ snap_q) & mask_i));

endmodule

// File: rtl/opm_clk_sel.sv
module opm_clk_sel #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic req_slow_i,
  input  logic cpu_run_i,
  output logic sel_o,
  output logic boundary_o,
  output logic ce_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sel_q;

  assign boundary_o = run_i && (cnt_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == DIV_LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Select moves only at the divider boundary; while stopped no clock runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= 1'b0;
    else if (!run_i)     sel_q <= req_slow_i;
    else if (boundary_o) sel_q <= req_slow_i;
  end

  assign sel_o = sel_q;
  assign ce_o  = cpu_run_i && (sel_q ? boundary_o : 1'b1);

endmodule

// File: rtl/opm_mode_fsm.sv
module opm_mode_fsm
  import opm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             port_wake_i,
  input  logic             green_wake_i,
  output opm_mode_e        mode_o,
  output opm_mode_e        ret_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             enter_halt_o
);

  opm_mode_e        mode_q, ret_q, tgt;
  logic [CTL_W-1:0] ctl_q;
  logic             wr_ok;

  assign tgt          = target_mode(wr_data_i);
  assign wr_ok        = wr_en_i && is_running(mode_q);
  assign enter_halt_o = wr_ok && !is_running(tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OPM_NORMAL;
      ret_q  <= OPM_NORMAL;
      ctl_q  <= '0;
    end else begin
      case (mode_q)
        OPM_NORMAL, OPM_SLOW: begin
          if (wr_ok) begin
            ctl_q  <= wr_data_i;
            mode_q <= tgt;
            if (tgt == OPM_GREEN) ret_q <= base_mode(wr_data_i);
          end
        end
        OPM_GREEN: begin
          if (port_wake_i || green_wake_i) begin
            mode_q           <= ret_q;
            ctl_q[CTL_GREEN] <= 1'b0;
          end
        end
        default: begin
          if (port_wake_i) begin
            mode_q <= OPM_NORMAL;
            ctl_q  <= '0;
          end
        end
      endcase
    end
  end

  assign mode_o = mode_q;
  assign ret_o  = ret_q;
  assign ctl_o  = ctl_q;

endmodule

// File: rtl/opm_ctrl.sv
module opm_ctrl
  import opm_pkg::*;
#(
  parameter int P0_W = 4,
  parameter int P1_W = 4,
  parameter int DIV  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_data,
  input  logic [P0_W-1:0] p0_pins,
  input  logic [P1_W-1:0] p1_pins,
  input  logic [P1_W-1:0] p1_wake_en,
  input  logic            green_wake,
  output logic [1:0]      mode_o,
  output logic [3:0]      ctl_o,
  output logic            hosc_en,
  output logic            losc_en,
  output logic            cpu_run,
  output logic            clk_sel_slow,
  output logic            sys_ce
);

  localparam int PW = P0_W + P1_W;

  logic [PW-1:0]    pins_sync;
  logic [PW-1:0]    wake_mask;
  logic             port_wake;
  logic             halted;
  logic             enter_halt;
  logic             sel_req;
  logic             div_boundary;
  logic             gwake_eff;
  opm_mode_e        mode_q, ret_q;
  logic [CTL_W-1:0] ctl_q;

  opm_sync #(.W(PW), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({p1_pins, p0_pins}),
    .q_o   (pins_sync)
  );

  assign wake_mask = {p1_wake_en, {P0_W{1'b1}}};
  assign halted    = !is_running(mode_q);

  opm_wake_det #(.W(PW)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_i    (pins_sync),
    .mask_i    (wake_mask),
    .capture_i (enter_halt),
    .armed_i   (halted),
    .change_o  (port_wake)
  );

  assign gwake_eff = green_wake && (mode_q == OPM_GREEN);

  opm_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .port_wake_i  (port_wake),
    .green_wake_i (gwake_eff),
    .mode_o       (mode_q),
    .ret_o        (ret_q),
    .ctl_o        (ctl_q),
    .enter_halt_o (enter_halt)
  );

  assign sel_req = (mode_q == OPM_SLOW) || (mode_q == OPM_GREEN && ret_q == OPM_SLOW);

  opm_clk_sel #(.DIV(DIV)) u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (losc_en),
    .req_slow_i (sel_req),
    .cpu_run_i  (cpu_run),
    .sel_o      (clk_sel_slow),
    .boundary_o (div_boundary),
    .ce_o       (sys_ce)
  );

  assign mode_o  = mode_q;
  assign ctl_o   = ctl_q;
  assign cpu_run = is_running(mode_q);
  assign losc_en = (mode_q != OPM_DOWN);
  assign hosc_en = hosc_needed(mode_q, ctl_q[CTL_STOPHI]);

endmodule

// File: rtl/opm_ctrl_chk.sv
module opm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [1:0] ret,
  input logic [3:0] ctl,
  input logic       port_wake,
  input logic       gwake,
  input logic       hosc_en,
  input logic       losc_en,
  input logic       cpu_run,
  input logic       sys_ce,
  input logic       sel,
  input logic       boundary,
  input logic       wr_en
);

  assert_down_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!hosc_en && !losc_en && !cpu_run && !sys_ce));

  assert_slow_hosc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (hosc_en == !ctl[1]));

  assert_down_wake_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && port_wake) |=> (mode == 2'd0 && ctl == 4'd0));

  assert_green_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && (port_wake || gwake)) |=> (mode == $past(ret) && !ctl[3]));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_run && !port_wake && !gwake) |=> ($stable(mode) && $stable(ctl)));

  assert_sel_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (losc_en && !boundary) |=> $stable(sel));

  assert_run_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run |-> (mode == 2'd0 || mode == 2'd1));

  assert_normal_ce_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_run && !sel) |-> sys_ce);

  assert_write_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cpu_run && mode == 2'd3 && !port_wake) |=> (mode == 2'd3));

endmodule

bind opm_ctrl opm_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode_q),
  .ret      (ret_q),
  .ctl      (ctl_q),
  .port_wake(port_wake),
  .gwake    (gwake_eff),
  .hosc_en  (hosc_en),
  .losc_en  (losc_en),
  .cpu_run  (cpu_run),
  .sys_ce   (sys_ce),
  .sel      (clk_sel_slow),
  .boundary (div_boundary),
  .wr_en    (wr_en)
);

// File: tb/opm_ctrl_tb.sv
module opm_ctrl_tb_top;

  localparam int P0_W = 4;
  localparam int P1_W = 4;
  localparam int DIV  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_data = '0;
  logic [P0_W-1:0] p0_pins = '0;
  logic [P1_W-1:0] p1_pins = '0;
  logic [P1_W-1:0] p1_wake_en = '0;
  logic            green_wake = 1'b0;
  logic [1:0]      mode_o;
  logic [3:0]      ctl_o;
  logic            hosc_en, losc_en, cpu_run, clk_sel_slow, sys_ce;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  opm_ctrl #(.P0_W(P0_W), .P1_W(P1_W), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .p0_pins(p0_pins), .p1_pins(p1_pins), .p1_wake_en(p1_wake_en),
    .green_wake(green_wake), .mode_o(mode_o), .ctl_o(ctl_o),
    .hosc_en(hosc_en), .losc_en(losc_en), .cpu_run(cpu_run),
    .clk_sel_slow(clk_sel_slow), .sys_ce(sys_ce)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected mode after a write, worked out from R2, R4, R5, R8.
  function automatic int exp_base(input logic [3:0] d);
    if (d[2]) return 3;
    if (!d[0] && d[1]) return 3;
    return d[0] ? 1 : 0;
  endfunction

  function automatic int exp_mode(input logic [3:0] d);
    int b;
    b = exp_base(d);
    if (b != 3 && d[3]) return 2;
    return b;
  endfunction

  function automatic int exp_hosc(input int m, input logic stop);
    if (m == 0) return 1;
    if (m == 3) return 0;
    return stop ? 0 : 1;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    p0_pins = '0; p1_pins = '0; green_wake = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(3);
  endtask

  task automatic write(input logic [3:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 mode", mode_o, 0);
    check("R1 ctl", ctl_o, 0);
    check("R1 hosc", hosc_en, 1);
    check("R1 losc", losc_en, 1);
    check("R1 run", cpu_run, 1);
    check("R1 sel", clk_sel_slow, 0);

    // Sweep every control word from both run modes (R2..R8)
    for (int start = 0; start < 2; start++) begin
      for (int dv = 0; dv < 16; dv++) begin
        logic [3:0] d;
        int m;
        d = 4'(dv);
        do_reset();
        if (start == 1) write(4'b0001);
        check("R2 start mode", mode_o, start);
        write(d);
        m = exp_mode(d);
        check(d[2] ? "R4 mode" : (d[1] && !d[0]) ? "R5 mode" : d[3] ? "R8 mode" : "R2 mode", mode_o, m);
        check("R2 ctl readback", ctl_o, dv);
        check("R3 hosc", hosc_en, exp_hosc(m, d[1]));
        check("R4 losc", losc_en, (m == 3) ? 0 : 1);
        check("R4 run", cpu_run, (m < 2) ? 1 : 0);
        if (m == 3) check("R4 ce", sys_ce, 0);
        if (m >= 2) begin
          // R9 write ignored while halted
          write(4'b0000);
          cycles(1);
          check("R9 mode held", mode_o, m);
          check("R9 ctl held", ctl_o, dv);
          p0_pins[0] = 1'b1;
          cycles(4);
          if (m == 3) begin
            check("R7 wake mode", mode_o, 0);
            check("R7 ctl cleared", ctl_o, 0);
          end else begin
            check("R8 return mode", mode_o, exp_base(d));
            check("R8 ctl wait cleared", ctl_o, dv & 7);
          end
          check("R6 run after wake", cpu_run, 1);
        end
      end
    end

    // R6 per-pin wake sweep with enable on and off
    for (int pin = 0; pin < P0_W + P1_W; pin++) begin
      for (int en = 0; en < 2; en++) begin
        do_reset();
        p1_wake_en = en ? '1 : '0;
        write(4'b0100);
        check("R6 halted", mode_o, 3);
        if (pin < P0_W) p0_pins[pin] = 1'b1;
        else            p1_pins[pin - P0_W] = 1'b1;
        cycles(4);
        check("R6 wake by pin", mode_o, (pin < P0_W || en == 1) ? 0 : 3);
      end
    end
    p1_wake_en = '0;

    // R8 timer wake ends wait, not power down
    do_reset();
    write(4'b1001);
    check("R8 wait entry", mode_o, 2);
    check("R8 wait hosc", hosc_en, 1);
    green_wake = 1'b1;
    cycles(1);
    green_wake = 1'b0;
    check("R8 timer wake to slow", mode_o, 1);
    check("R8 ctl", ctl_o, 1);
    do_reset();
    write(4'b0100);
    green_wake = 1'b1;
    cycles(6);
    green_wake = 1'b0;
    check("R8 timer ignored in down", mode_o, 3);

    // R10 clock select timing and strobe rate
    do_reset();
    check("R10 normal ce", sys_ce, 1);
    write(4'b0001);
    begin
      int waited;
      waited = 0;
      while (!clk_sel_slow && waited < 3 * DIV) begin
        cycles(1);
        waited++;
      end
      check("R10 sel within DIV", (waited <= DIV) ? 1 : 0, 1);
    end
    begin
      int pulses, last, gap_bad;
      pulses = 0; last = -1; gap_bad = 0;
      for (int c = 0; c < 4 * DIV; c++) begin
        if (sys_ce) begin
          if (last >= 0 && c - last != DIV) gap_bad++;
          last = c;
          pulses++;
        end
        cycles(1);
      end
      check("R10 slow pulses", pulses, 4);
      check("R10 slow gap", gap_bad, 0);
    end
    write(4'b0000);
    cycles(DIV + 1);
    check("R10 sel back", clk_sel_slow, 0);
    check("R10 ce back", sys_ce, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule